// File: doc/BRIEF.md
# CAN Driver-Enable Supervisor with Stuck-Dominant Time-Out

This block sits between the transmit output of a CAN protocol controller and the enable input of a bus line driver. It decides, every clock cycle, whether the driver may pull the bus dominant. The controller's transmit level (low means dominant) only turns the driver on when nothing blocks it. Four things can block it: a listen-only (silent) request, an over-temperature flag, a supply-undervoltage flag, and a built-in stuck-dominant time-out.

The time-out counts clock cycles while the synchronized transmit level stays low. When the count reaches `TMO_CYCLES`, the driver is released. It stays released, and a status flag stays high, until the transmit line goes back to recessive. Choose `TMO_CYCLES` so that the period falls between 300 µs and 700 µs; the default of 22500 gives 450 µs at 50 MHz. The counter keeps running while another source masks the driver, so lifting that mask late in a long dominant phase does not restart the allowance.

Each input carries a valid qualifier. An unqualified (floating) transmit line counts as recessive, and an unqualified silent select counts as normal mode. The fault flags arrive already clean and are applied without delay.

Top module: `can_drv_guard`

## Requirements
- R1: `drv_en_o` is high only when the synchronized transmit level is dominant (valid and low) and no block is active. `bus_lvl_o` is 0 (dominant) exactly when `drv_en_o` is high, and 1 (recessive) otherwise.
- R2: A change on `txd_i`, `txd_vld_i`, `silent_i` or `silent_vld_i` reaches `drv_en_o` after exactly two rising clock edges.
- R3: In one continuous dominant phase, the driver is enabled for at most `TMO_CYCLES` cycles. `tmo_o` rises on the edge that would have started cycle `TMO_CYCLES`+1.
- R4: After a time-out, the driver stays off while the transmit level stays low. Once the transmit level returns recessive, `tmo_o` clears on the third rising edge. A new dominant request then enables the driver again after two edges.
- R5: When `silent_i` is qualified high, the driver stays off whatever the transmit level.
- R6: While `ovt_i` is high, `drv_en_o` is low in the same cycle. When `ovt_i` drops, the driver resumes immediately if a dominant request is still pending within the time-out allowance.
- R7: While `uv_i` is high, `drv_en_o` is low in the same cycle.
- R8: When `txd_vld_i` is low, the transmit input counts as recessive. When `silent_vld_i` is low, the block runs in normal mode.
- R9: The time-out counter keeps counting while silent mode or a fault masks the driver. If the mask lifts after the period has expired, the driver stays off and `tmo_o` is high.
- R10: A dominant pulse of L < `TMO_CYCLES` cycles enables the driver for exactly L cycles and leaves `tmo_o` low and no state behind.
- R11: While `rst_ni` is low, `drv_en_o` and `tmo_o` are 0 and `bus_lvl_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit level from the controller, 0 = dominant |
| txd_vld_i | input | 1 | Qualifier for txd_i; 0 means floating (recessive) |
| silent_i | input | 1 | Listen-only request, 1 = driver off |
| silent_vld_i | input | 1 | Qualifier for silent_i; 0 means floating (normal) |
| ovt_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| drv_en_o | output | 1 | Driver enable, 1 = drive bus dominant |
| bus_lvl_o | output | 1 | Effective bus level, 0 = dominant, 1 = recessive |
| tmo_o | output | 1 | Stuck-dominant time-out status |

## Verification
Dominant pulses of every length from 1 cycle to a few cycles beyond a small time-out are applied, and the enable and status outputs are compared on every cycle. Pulses shorter than, equal to and longer than the period show the exact pass-through width, the two-edge latency and the release point. All 32 combinations of the two qualifiers, the silent select and the two fault flags are tried against a pending dominant request. This separates which blocking source wins and how floating inputs default. Directed sequences cover three further cases: a mask lifted after expiry, the return-to-recessive re-arm, and an over-temperature pulse that resumes driving in the middle of a frame.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  typedef enum logic {BUS_DOM = 1'b0, BUS_REC = 1'b1} bus_lvl_e;

  // unqualified transmit line reads recessive
  function automatic logic eff_txd(input logic vld, input logic lvl);
    return vld ? lvl : 1'b1;
  endfunction

  // unqualified silent select reads normal mode
  function automatic logic eff_silent(input logic vld, input logic lvl);
    return vld ? lvl : 1'b0;
  endfunction
endpackage

// File: rtl/can_guard_sync.sv
module can_guard_sync #(
  parameter int unsigned    W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/can_guard_dom_timer.sv
module can_guard_dom_timer #(
  parameter int unsigned TMO_CYCLES = 22500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_s_i,
  output logic tmo_o
);
  localparam int unsigned   CW   = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(TMO_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          tmo_q;

  // recessive level clears; count restarts from the falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (txd_s_i) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) tmo_q <= 1'b1;
    end
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/can_guard_gate.sv
module can_guard_gate (
  input  logic txd_s_i,
  input  logic silent_s_i,
  input  logic ovt_i,
  input  logic uv_i,
  input  logic tmo_i,
  output logic drv_en_o
);
  logic blocked;

  assign blocked  = silent_s_i | ovt_i | uv_i | tmo_i;
  assign drv_en_o = ~txd_s_i & ~blocked;
endmodule

// File: rtl/can_drv_guard.sv
module can_drv_guard
  import can_guard_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 22500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic txd_vld_i,
  input  logic silent_i,
  input  logic silent_vld_i,
  input  logic ovt_i,
  input  logic uv_i,
  output logic drv_en_o,
  output logic bus_lvl_o,
  output logic tmo_o
);
  logic [1:0] raw_in, syn_q;
  logic       txd_s, silent_s, tmo_s, drv_en;
  bus_lvl_e   lvl;

  assign raw_in = {eff_silent(silent_vld_i, silent_i), eff_txd(txd_vld_i, txd_i)};

  can_guard_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_q)
  );

  assign txd_s    = syn_q[0];
  assign silent_s = syn_q[1];

  can_guard_dom_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txd_s_i(txd_s),
    .tmo_o  (tmo_s)
  );

  can_guard_gate u_gate (
    .txd_s_i   (txd_s),
    .silent_s_i(silent_s),
    .ovt_i     (ovt_i),
    .uv_i      (uv_i),
    .tmo_i     (tmo_s),
    .drv_en_o  (drv_en)
  );

  assign lvl       = drv_en ? BUS_DOM : BUS_REC;
  assign drv_en_o  = drv_en;
  assign bus_lvl_o = lvl;
  assign tmo_o     = tmo_s;
endmodule

// File: rtl/can_drv_guard_chk.sv
module can_drv_guard_chk #(
  parameter int unsigned TMO_CYCLES = 22500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic txd_vld_i,
  input logic silent_i,
  input logic silent_vld_i,
  input logic ovt_i,
  input logic uv_i,
  input logic drv_en_o,
  input logic bus_lvl_o,
  input logic tmo_o
);
  localparam int unsigned CW = $clog2(TMO_CYCLES + 1) + 1;

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hi_cnt_q <= '0;
    else if (!drv_en_o)       hi_cnt_q <= '0;
    else if (~&hi_cnt_q)      hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_dom_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> $past(txd_vld_i && !txd_i, 2));

  assert_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> (hi_cnt_q < CW'(TMO_CYCLES)));

  assert_clear_needs_rec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmo_o) |-> $past(!txd_vld_i || txd_i, 3));

  assert_silent_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !$past(silent_vld_i && silent_i, 2));

  assert_ovt_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovt_i |-> !drv_en_o);

  assert_uv_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !drv_en_o);

  assert_tmo_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> !drv_en_o && bus_lvl_o);
endmodule

bind can_drv_guard can_drv_guard_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .txd_i       (txd_i),
  .txd_vld_i   (txd_vld_i),
  .silent_i    (silent_i),
  .silent_vld_i(silent_vld_i),
  .ovt_i       (ovt_i),
  .uv_i        (uv_i),
  .drv_en_o    (drv_en_o),
  .bus_lvl_o   (bus_lvl_o),
  .tmo_o       (tmo_o)
);

// File: tb/tb_can_drv_guard.sv
module tb_can_drv_guard;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_ni, txd_i, txd_vld_i, silent_i, silent_vld_i, ovt_i, uv_i;
  logic drv_en_o, bus_lvl_o, tmo_o;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  can_drv_guard #(.TMO_CYCLES(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd_i), .txd_vld_i(txd_vld_i),
    .silent_i(silent_i), .silent_vld_i(silent_vld_i), .ovt_i(ovt_i), .uv_i(uv_i),
    .drv_en_o(drv_en_o), .bus_lvl_o(bus_lvl_o), .tmo_o(tmo_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle_rec();
    txd_i = 1'b1; txd_vld_i = 1'b1; silent_i = 1'b0; silent_vld_i = 1'b1;
    ovt_i = 1'b0; uv_i = 1'b0;
    tick(4);
  endtask

  initial begin
    rst_ni = 1'b0; txd_i = 1'b0; txd_vld_i = 1'b1; silent_i = 1'b0;
    silent_vld_i = 1'b1; ovt_i = 1'b0; uv_i = 1'b0;
    tick(3);
    chk(drv_en_o, 1'b0, "R11 drv in reset");
    chk(tmo_o, 1'b0, "R11 tmo in reset");
    chk(bus_lvl_o, 1'b1, "R11 bus level in reset");
    rst_ni = 1'b1;
    idle_rec();

    // pulse-length sweep: R2 R3 R10
    for (int len = 1; len <= TMO + 3; len++) begin
      int on_len;
      on_len = (len < TMO) ? len : TMO;
      @(negedge clk);
      txd_i = 1'b0;
      for (int n = 1; n <= len + 6; n++) begin
        logic e_drv, e_tmo;
        tick(1);
        e_drv = (n >= 2) && (n <= on_len + 1);
        e_tmo = (len >= TMO) && (n >= TMO + 2) && (n <= len + 2);
        chk(drv_en_o, e_drv, $sformatf("R2 R3 R10 drv len=%0d n=%0d", len, n));
        chk(bus_lvl_o, ~e_drv, $sformatf("R1 bus level len=%0d n=%0d", len, n));
        chk(tmo_o, e_tmo, $sformatf("R3 R4 tmo len=%0d n=%0d", len, n));
        if (n == len) txd_i = 1'b1;
      end
    end

    // re-arm after time-out: R4
    idle_rec();
    txd_i = 1'b0;
    tick(TMO + 5);
    chk(drv_en_o, 1'b0, "R4 held off while dominant");
    chk(tmo_o, 1'b1, "R4 tmo held while dominant");
    txd_i = 1'b1;
    tick(2);
    chk(tmo_o, 1'b1, "R4 tmo before clear edge");
    tick(1);
    chk(tmo_o, 1'b0, "R4 tmo cleared by recessive");
    txd_i = 1'b0;
    tick(2);
    chk(drv_en_o, 1'b1, "R4 re-armed driver");
    idle_rec();

    // counter runs under mask: R9
    silent_i = 1'b1;
    txd_i = 1'b0;
    tick(TMO + 4);
    silent_i = 1'b0;
    tick(3);
    chk(drv_en_o, 1'b0, "R9 stays off after mask lifts");
    chk(tmo_o, 1'b1, "R9 tmo set under mask");
    idle_rec();

    // over-temperature mid-frame: R6
    txd_i = 1'b0;
    tick(3);
    chk(drv_en_o, 1'b1, "R6 driving before fault");
    ovt_i = 1'b1;
    #1;
    chk(drv_en_o, 1'b0, "R6 off on over-temperature");
    tick(1);
    ovt_i = 1'b0;
    #1;
    chk(drv_en_o, 1'b1, "R6 resumes after fault");
    uv_i = 1'b1;
    #1;
    chk(drv_en_o, 1'b0, "R7 off on undervoltage");
    idle_rec();

    // exhaustive mode sweep: R1 R5 R6 R7 R8
    for (int m = 0; m < 32; m++) begin
      logic e;
      idle_rec();
      txd_i = 1'b0;
      txd_vld_i = m[0]; silent_vld_i = m[1]; silent_i = m[2];
      ovt_i = m[3]; uv_i = m[4];
      tick(3);
      e = m[0] & ~(m[1] & m[2]) & ~m[3] & ~m[4];
      chk(drv_en_o, e, $sformatf("R1 R5 R6 R7 R8 mode=%0d", m));
      chk(bus_lvl_o, ~e, $sformatf("R1 bus level mode=%0d", m));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule